// File: doc/BRIEF.md
# Three-Level PWM Bridge Driver with Dead-Time Guard

The block turns a stream of signed samples into gate enables for the four switches of a full H-bridge. It makes one carrier period for each oversampled sample. A sawtooth slot counter splits that period into 2^(SAMPLE_W-1) clock slots. The sign of the sample picks which leg pulses. A positive sample drives leg A between the supply and ground while leg B stays at ground. A negative sample does the mirror image. A zero sample holds both legs at ground, so no switch changes state. The pulse width in slots equals the sample magnitude. It is clamped so that neither the high interval nor the low interval of the word is shorter than the guard length.

Each leg has its own dead-time state machine with the states OFF, LOW, DEAD_UP, HIGH and DEAD_DOWN. OFF goes directly to LOW or HIGH on the first carrier start. LOW goes to DEAD_UP when the pulse demand rises. DEAD_UP goes to HIGH after DEAD_TICKS cycles, or to DEAD_DOWN if the demand drops. HIGH goes to DEAD_DOWN when the demand falls. DEAD_DOWN goes to LOW after DEAD_TICKS cycles, or to DEAD_UP if the demand returns. During both dead states the two switches of the leg are off.

The carrier has its own state machine with the states WAIT and RUN. WAIT holds every gate off until the first slot counter wrap. That wrap moves it to RUN for good. The guard length is a configured count of clock ticks plus a small signed trim. A load-current sign bit adjusts the trim by one tick (10 ns at a 100 MHz clock) once every TRIM_EVERY carrier periods.

Top module: `ternary_pwm_gen`

## Requirements
- R1: While reset is asserted, and for the first 2^(SAMPLE_W-1) clock cycles after it is released, all four gate outputs are 0.
- R2: When the sample is zero, both low-side enables stay at 1 and no gate output toggles.
- R3: The sample is two's complement, and bit SAMPLE_W-1 is its sign. For a positive sample of effective width w, leg A has its high side on for w-DEAD_TICKS cycles and its low side on for PERIOD-w-DEAD_TICKS cycles in every period. Leg B has its low side on for the whole period.
- R4: A negative sample gives the same pattern on leg B, with leg A held low. The magnitude is the two's complement negation, so the most negative code has magnitude PERIOD.
- R5: The two high-side enables are never on in the same cycle.
- R6: The high and low enables of a leg are never on together. Between them are DEAD_TICKS cycles with both off, so each pulsing period has 2·DEAD_TICKS dead cycles per leg.
- R7: A nonzero magnitude below the guard length g gives a width of g.
- R8: A magnitude above PERIOD-g gives a width of PERIOD-g.
- R9: The guard g is the configured count plus the trim, saturated to the range [DEAD_TICKS+1, PERIOD/4]. The sample and the guard are taken only at the end of a carrier period.
- R10: Once every TRIM_EVERY periods the trim moves by one tick. It goes up when the current-sign bit is 1 and down when it is 0, and it saturates at ±TRIM_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | SAMPLE_W | Signed sample, held for a carrier period |
| guard_cfg_i | input | GUARD_W | Configured guard length in clock ticks |
| isense_i | input | 1 | Load-current sign feedback |
| a_hi_o | output | 1 | Leg A high-side enable |
| a_lo_o | output | 1 | Leg A low-side enable |
| b_hi_o | output | 1 | Leg B high-side enable |
| b_lo_o | output | 1 | Leg B low-side enable |

## Verification
The bench holds each sample for several periods. It then counts the high and low on-cycles of each leg over one period-long window. This makes the counts independent of where the slot counter stands. Tiny and full-scale magnitudes are among the samples. A design without the clamps would show a high time of zero or a negative value in place of the expected counts.

The most negative code is included. A design that negates it wrongly would give a width of zero, or would steer it to the wrong leg. A zero sample must show no toggles at all. A modulator that drives both legs at 50% duty would fail that check. The guard is also pushed against both saturation limits through the trim and the configured value. A design that lets the trim wrap, or skips the limits, would give pulse widths other than the computed ones.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [2:0] {
        LEG_OFF,
        LEG_LO,
        LEG_DT_HI,
        LEG_HI,
        LEG_DT_LO
    } leg_state_e;

    typedef enum logic {
        CAR_WAIT,
        CAR_RUN
    } car_state_e;

endpackage

// File: rtl/tpg_guard_trim.sv
module tpg_guard_trim #(
    parameter int GUARD_W    = 5,
    parameter int TRIM_MAX   = 2,
    parameter int TRIM_EVERY = 4,
    parameter int GUARD_MIN  = 3,
    parameter int GUARD_MAX  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary_i,
    input  logic               isense_i,
    input  logic [GUARD_W-1:0] cfg_i,
    output logic [GUARD_W-1:0] guard_o
);
    localparam int TRIM_W = $clog2(TRIM_MAX + 1) + 1;
    localparam int PC_W   = $clog2(TRIM_EVERY + 1);
    localparam int SUM_W  = GUARD_W + 2;
    localparam logic signed [TRIM_W-1:0] TMAX_S = TRIM_W'(TRIM_MAX);
    localparam logic signed [TRIM_W-1:0] TMIN_S = -TMAX_S;
    localparam logic signed [SUM_W-1:0]  GMIN_S = SUM_W'(GUARD_MIN);
    localparam logic signed [SUM_W-1:0]  GMAX_S = SUM_W'(GUARD_MAX);

    logic signed [TRIM_W-1:0] trim_q, trim_nx;
    logic [PC_W-1:0]          pcnt_q;
    logic                     step;
    logic signed [SUM_W-1:0]  sum;

    // trim moves on the last period of each trim window
    always_comb begin
        step    = boundary_i && (pcnt_q == PC_W'(TRIM_EVERY - 1));
        trim_nx = trim_q;
        if (step) begin
            if (isense_i && (trim_q < TMAX_S))
                trim_nx = trim_q + 1'b1;
            else if (!isense_i && (trim_q > TMIN_S))
                trim_nx = trim_q - 1'b1;
        end
    end

    always_comb begin
        sum = $signed({2'b00, cfg_i}) +
              $signed({{(SUM_W - TRIM_W){trim_nx[TRIM_W-1]}}, trim_nx});
        if (sum < GMIN_S)
            guard_o = GUARD_W'(GUARD_MIN);
        else if (sum > GMAX_S)
            guard_o = GUARD_W'(GUARD_MAX);
        else
            guard_o = sum[GUARD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trim_q <= '0;
            pcnt_q <= '0;
        end else if (boundary_i) begin
            trim_q <= trim_nx;
            pcnt_q <= step ? '0 : pcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tpg_carrier.sv
module tpg_carrier
    import tpg_pkg::*;
#(
    parameter int SAMPLE_W = 6,
    parameter int GUARD_W  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [GUARD_W-1:0]  guard_i,
    output logic                boundary_o,
    output logic                run_o,
    output logic [SAMPLE_W-1:0] width_o,
    output logic                want_a_o,
    output logic                want_b_o
);
    localparam int CNT_W  = SAMPLE_W - 1;
    localparam int MAG_W  = SAMPLE_W;
    localparam int PERIOD = 1 << CNT_W;

    car_state_e       state_q, state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [MAG_W-1:0] width_q;
    logic             neg_q;
    logic [MAG_W-1:0] mag;
    logic [MAG_W:0]   g_ext, top_lim, width_nx;

    assign boundary_o = (cnt_q == CNT_W'(PERIOD - 1));

    // magnitude and guard clamps
    always_comb begin
        mag     = sample_i[SAMPLE_W-1] ? (~sample_i + 1'b1) : sample_i;
        g_ext   = (MAG_W + 1)'(guard_i);
        top_lim = (MAG_W + 1)'(PERIOD) - g_ext;
        if (mag == '0)
            width_nx = '0;
        else if ({1'b0, mag} < g_ext)
            width_nx = g_ext;
        else if ({1'b0, mag} > top_lim)
            width_nx = top_lim;
        else
            width_nx = {1'b0, mag};
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            CAR_WAIT: if (boundary_o) state_nx = CAR_RUN;
            CAR_RUN:  state_nx = CAR_RUN;
            default:  state_nx = CAR_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAR_WAIT;
            cnt_q   <= '0;
            width_q <= '0;
            neg_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_q + 1'b1;
            if (boundary_o) begin
                width_q <= width_nx[MAG_W-1:0];
                neg_q   <= sample_i[SAMPLE_W-1];
            end
        end
    end

    always_comb begin
        run_o    = (state_q == CAR_RUN);
        width_o  = width_q;
        want_a_o = run_o && !neg_q && ({1'b0, cnt_q} < width_q);
        want_b_o = run_o &&  neg_q && ({1'b0, cnt_q} < width_q);
    end

endmodule

// File: rtl/tpg_dead_leg.sv
module tpg_dead_leg
    import tpg_pkg::*;
#(
    parameter int DEAD_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic want_i,
    output logic hi_o,
    output logic lo_o
);
    localparam int DC_W = $clog2(DEAD_TICKS + 1);
    localparam logic [DC_W-1:0] DLOAD = DC_W'(DEAD_TICKS - 1);

    leg_state_e      state_q, state_nx;
    logic [DC_W-1:0] dcnt_q, dcnt_nx;

    always_comb begin
        state_nx = state_q;
        dcnt_nx  = dcnt_q;
        unique case (state_q)
            LEG_OFF: begin
                if (en_i) state_nx = want_i ? LEG_HI : LEG_LO;
            end
            LEG_LO: begin
                if (want_i) begin
                    state_nx = LEG_DT_HI;
                    dcnt_nx  = DLOAD;
                end
            end
            LEG_DT_HI: begin
                if (!want_i) begin
                    state_nx = LEG_DT_LO;
                    dcnt_nx  = DLOAD;
                end else if (dcnt_q == '0) begin
                    state_nx = LEG_HI;
                end else begin
                    dcnt_nx = dcnt_q - 1'b1;
                end
            end
            LEG_HI: begin
                if (!want_i) begin
                    state_nx = LEG_DT_LO;
                    dcnt_nx  = DLOAD;
                end
            end
            LEG_DT_LO: begin
                if (want_i) begin
                    state_nx = LEG_DT_HI;
                    dcnt_nx  = DLOAD;
                end else if (dcnt_q == '0) begin
                    state_nx = LEG_LO;
                end else begin
                    dcnt_nx = dcnt_q - 1'b1;
                end
            end
            default: state_nx = LEG_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LEG_OFF;
            dcnt_q  <= '0;
        end else begin
            state_q <= state_nx;
            dcnt_q  <= dcnt_nx;
        end
    end

    always_comb begin
        hi_o = 1'b0;
        lo_o = 1'b0;
        unique case (state_q)
            LEG_HI:  hi_o = 1'b1;
            LEG_LO:  lo_o = 1'b1;
            default: begin
                hi_o = 1'b0;
                lo_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ternary_pwm_gen.sv
module ternary_pwm_gen #(
    parameter int SAMPLE_W   = 6,
    parameter int GUARD_W    = 5,
    parameter int DEAD_TICKS = 2,
    parameter int TRIM_MAX   = 2,
    parameter int TRIM_EVERY = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [GUARD_W-1:0]  guard_cfg_i,
    input  logic                isense_i,
    output logic                a_hi_o,
    output logic                a_lo_o,
    output logic                b_hi_o,
    output logic                b_lo_o
);
    localparam int PERIOD    = 1 << (SAMPLE_W - 1);
    localparam int GUARD_MIN = DEAD_TICKS + 1;
    localparam int GUARD_MAX = PERIOD / 4;
    localparam int NUM_LEGS  = 2;

    logic                boundary_w, run_w;
    logic [GUARD_W-1:0]  guard_w;
    logic [SAMPLE_W-1:0] width_w;
    logic [NUM_LEGS-1:0] want_w, hi_w, lo_w;

    tpg_guard_trim #(
        .GUARD_W   (GUARD_W),
        .TRIM_MAX  (TRIM_MAX),
        .TRIM_EVERY(TRIM_EVERY),
        .GUARD_MIN (GUARD_MIN),
        .GUARD_MAX (GUARD_MAX)
    ) u_trim (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary_i(boundary_w),
        .isense_i  (isense_i),
        .cfg_i     (guard_cfg_i),
        .guard_o   (guard_w)
    );

    tpg_carrier #(
        .SAMPLE_W(SAMPLE_W),
        .GUARD_W (GUARD_W)
    ) u_car (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_i  (sample_i),
        .guard_i   (guard_w),
        .boundary_o(boundary_w),
        .run_o     (run_w),
        .width_o   (width_w),
        .want_a_o  (want_w[0]),
        .want_b_o  (want_w[1])
    );

    for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
        tpg_dead_leg #(
            .DEAD_TICKS(DEAD_TICKS)
        ) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (run_w),
            .want_i(want_w[i]),
            .hi_o  (hi_w[i]),
            .lo_o  (lo_w[i])
        );
    end

    assign a_hi_o = hi_w[0];
    assign a_lo_o = lo_w[0];
    assign b_hi_o = hi_w[1];
    assign b_lo_o = lo_w[1];

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
    parameter int MAG_W     = 6,
    parameter int GUARD_MIN = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_hi,
    input logic             a_lo,
    input logic             b_hi,
    input logic             b_lo,
    input logic             run,
    input logic [MAG_W-1:0] width
);
    // R6
    a_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_hi && a_lo));
    // R6
    b_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_hi && b_lo));
    // R6
    a_dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(a_hi) |-> !a_lo);
    // R6
    b_dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_lo) |-> !b_hi);
    // R5
    high_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_hi && b_hi));
    // R1
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !(a_hi || a_lo || b_hi || b_lo));
    // R7
    width_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && width != '0) |-> (width >= MAG_W'(GUARD_MIN)));
    // R2
    zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && width == '0) |-> !(a_hi || b_hi));
endmodule

bind ternary_pwm_gen tpg_checker #(
    .MAG_W    (SAMPLE_W),
    .GUARD_MIN(GUARD_MIN)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .a_hi (a_hi_o),
    .a_lo (a_lo_o),
    .b_hi (b_hi_o),
    .b_lo (b_lo_o),
    .run  (run_w),
    .width(width_w)
);

// File: tb/sim_ternary_pwm_gen.sv
module sim_ternary_pwm_gen;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;
    localparam int D = 2;
    localparam int SETTLE = 3 * N;
    localparam int TRIM_SETTLE = 25 * N;

    // columns: sample, a_hi cycles, a_lo cycles, b_hi cycles, b_lo cycles, requirement
    // guard is 3 here (cfg 4, trim saturated at -2)
    localparam int VEC [8][6] = '{
        '{  0,  0, 32,  0, 32, 2 },   // R2 zero
        '{ 10,  8, 20,  0, 32, 3 },   // R3 positive
        '{-10,  0, 32,  8, 20, 4 },   // R4 negative
        '{  1,  1, 27,  0, 32, 7 },   // R7 min clamp
        '{ 31, 27,  1,  0, 32, 8 },   // R8 max clamp
        '{-32,  0, 32, 27,  1, 8 },   // R8 most negative code
        '{  3,  1, 27,  0, 32, 7 },   // R7 at guard
        '{-15,  0, 32, 13, 15, 4 }    // R4
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] sample_i = '0;
    logic [4:0] guard_cfg_i = 5'd4;
    logic       isense_i = 1'b0;
    logic       a_hi_o, a_lo_o, b_hi_o, b_lo_o;

    int total = 0;
    int bad = 0;
    int ov_cnt = 0;
    int hh_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ternary_pwm_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_i   (sample_i),
        .guard_cfg_i(guard_cfg_i),
        .isense_i   (isense_i),
        .a_hi_o     (a_hi_o),
        .a_lo_o     (a_lo_o),
        .b_hi_o     (b_hi_o),
        .b_lo_o     (b_lo_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic measure(output int ha, output int la, output int hb,
                           output int lb, output int tog);
        logic [3:0] prev, cur;
        ha = 0; la = 0; hb = 0; lb = 0; tog = 0;
        @(negedge clk);
        prev = {a_hi_o, a_lo_o, b_hi_o, b_lo_o};
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            cur = {a_hi_o, a_lo_o, b_hi_o, b_lo_o};
            if (cur != prev) tog++;
            ha += int'(a_hi_o);
            la += int'(a_lo_o);
            hb += int'(b_hi_o);
            lb += int'(b_lo_o);
            prev = cur;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if ((a_hi_o && a_lo_o) || (b_hi_o && b_lo_o)) ov_cnt++;
            if (a_hi_o && b_hi_o) hh_cnt++;
        end
    end

    initial begin
        int ha, la, hb, lb, tog, off;
        // R1: outputs off during reset and the first period after release
        sample_i = 6'd10;
        repeat (5) @(negedge clk);
        chk("R1 in reset", int'({a_hi_o, a_lo_o, b_hi_o, b_lo_o}), 0);
        rst_n = 1'b1;
        off = 0;
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            off += int'(a_hi_o | a_lo_o | b_hi_o | b_lo_o);
        end
        chk("R1 first period", off, 0);

        // bring trim to its lower limit
        repeat (TRIM_SETTLE) @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            sample_i = 6'(VEC[i][0]);
            repeat (SETTLE) @(negedge clk);
            measure(ha, la, hb, lb, tog);
            chk($sformatf("R%0d a_hi s=%0d", VEC[i][5], VEC[i][0]), ha, VEC[i][1]);
            chk($sformatf("R%0d a_lo s=%0d", VEC[i][5], VEC[i][0]), la, VEC[i][2]);
            chk($sformatf("R%0d b_hi s=%0d", VEC[i][5], VEC[i][0]), hb, VEC[i][3]);
            chk($sformatf("R%0d b_lo s=%0d", VEC[i][5], VEC[i][0]), lb, VEC[i][4]);
            if (VEC[i][0] == 0) chk("R2 toggles on zero", tog, 0);
            if (VEC[i][0] == 10) chk("R6 dead cycles leg A", N - ha - la, 2 * D);
        end

        // R10: trim saturates up at +2, guard 4+2=6
        isense_i = 1'b1;
        sample_i = 6'd1;
        repeat (TRIM_SETTLE) @(negedge clk);
        measure(ha, la, hb, lb, tog);
        chk("R10 a_hi trim up", ha, 6 - D);
        chk("R10 a_lo trim up", la, N - 6 - D);

        // R9: guard saturates at PERIOD/4 = 8
        guard_cfg_i = 5'd20;
        repeat (SETTLE) @(negedge clk);
        measure(ha, la, hb, lb, tog);
        chk("R9 a_hi guard max", ha, 8 - D);
        chk("R9 a_lo guard max", la, N - 8 - D);
        sample_i = 6'd31;
        repeat (SETTLE) @(negedge clk);
        measure(ha, la, hb, lb, tog);
        chk("R8 a_hi wide guard", ha, 24 - D);
        chk("R8 a_lo wide guard", la, N - 24 - D);

        // R9: guard floor at DEAD_TICKS+1 = 3
        guard_cfg_i = 5'd0;
        isense_i = 1'b0;
        sample_i = 6'd1;
        repeat (TRIM_SETTLE) @(negedge clk);
        measure(ha, la, hb, lb, tog);
        chk("R9 a_hi guard min", ha, 3 - D);
        chk("R9 a_lo guard min", la, N - 3 - D);

        chk("R6 leg overlap cycles", ov_cnt, 0);
        chk("R5 both high cycles", hh_cnt, 0);

        // R1: reset mid-run forces all off
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 mid-run reset", int'({a_hi_o, a_lo_o, b_hi_o, b_lo_o}), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R1..: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule